// File: doc/BRIEF.md
# Parallel Prefix Adder

This block adds two unsigned operands of a parameterised width and a carry-in. It works out every carry position at once. Each bit first forms a generate flag (both operand bits set) and a propagate flag (the operand bits differ). An associative merge cell then folds these pairs together across the word, so each position ends up with the carry that reaches it. The carry-in enters as an extra generate term below bit 0. The sum is the propagate flag of each bit XORed with the carry into that bit.

A parameter picks one of two prefix-tree shapes, and both give the same result:

- **Doubling-distance tree.** It has log2(width) levels and a merge cell at nearly every node.
- **Sparse tree.** It builds power-of-two spans going up, then fills in the remaining positions coming back down. This uses fewer cells and about twice as many levels.

The sum and carry-out are captured in registers, so a result appears one clock after its operands. The width must be a power of two.

Top module: `ppa_adder`

## Requirements
- R1: `sum_o` equals (`a_i` + `b_i` + `cin_i`) modulo 2^WIDTH for any operand pair.
- R2: `cout_o` equals bit WIDTH of the full sum `a_i` + `b_i` + `cin_i`, including when a carry travels from bit 0 to the top bit.
- R3: `cin_i` acts as the carry into bit 0. With both operands zero, the result is `sum_o` = `cin_i` and `cout_o` = 0.
- R4: When every bit propagates (`a_i` XOR `b_i` all ones), `cout_o` equals `cin_i`. `sum_o` is all ones when `cin_i` = 0 and all zeros when `cin_i` = 1.
- R5: If both top operand bits are 1, `cout_o` is 1. If both top operand bits are 0, `cout_o` is 0.
- R6: Outputs are registered. The result for the operands present at a rising edge appears after that edge and holds until the next edge.
- R7: `rst` is synchronous and active high. While it is sampled high, `sum_o` and `cout_o` are 0 on the following cycle, whatever the operands.
- R8: The doubling-distance tree (TREE = TREE_KS) and the sparse tree (TREE = TREE_BK) produce identical outputs for identical inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Registered sum |
| cout_o | output | 1 | Registered carry out of the top bit |

## Verification
Two functions can meet in one cycle: carry-in injection and a full-length propagate chain. The bench provokes this by applying all-ones against zero, and alternating bit patterns, with `cin_i` set, so the carry-in must cross every prefix level before it reaches `cout_o`. It also drives reset high while the operands would produce a carry-out, so that reset and the arithmetic collide in the same cycle. A behavioural model delays each expected value by one cycle and judges both tree variants on every clock. Each variant is compared against the model and against the other.

// File: rtl/ppa_pkg.sv
`timescale 1ns/1ps
package ppa_pkg;

  typedef enum logic {
    TREE_KS = 1'b0,
    TREE_BK = 1'b1
  } tree_e;

  typedef struct packed {
    logic g;
    logic p;
  } gp_t;

  // Merge cell: the higher-significance pair must be the first argument.
  function automatic gp_t gp_merge(gp_t hi, gp_t lo);
    gp_t r;
    r.g = hi.g | (hi.p & lo.g);
    r.p = hi.p & lo.p;
    return r;
  endfunction

endpackage

// File: rtl/ppa_gp_gen.sv
`timescale 1ns/1ps
module ppa_gp_gen #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0]           a_i,
  input  logic [WIDTH-1:0]           b_i,
  input  logic                       cin_i,
  output ppa_pkg::gp_t [WIDTH-1:0]   leaf_o,
  output logic [WIDTH-1:0]           prop_o
);
  import ppa_pkg::*;

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_bit
      logic gen_b, prop_b;
      assign gen_b  = a_i[i] & b_i[i];
      assign prop_b = a_i[i] ^ b_i[i];
      assign prop_o[i] = prop_b;
      if (i == 0) begin : g_lsb
        // carry-in folded in as a generate term below bit 0
        assign leaf_o[i].g = gen_b | (prop_b & cin_i);
      end else begin : g_rest
        assign leaf_o[i].g = gen_b;
      end
      assign leaf_o[i].p = prop_b;
    end
  endgenerate
endmodule

// File: rtl/ppa_tree_ks.sv
`timescale 1ns/1ps
module ppa_tree_ks #(
  parameter int WIDTH = 16
) (
  input  ppa_pkg::gp_t [WIDTH-1:0] leaf_i,
  output ppa_pkg::gp_t [WIDTH-1:0] pref_o
);
  import ppa_pkg::*;

  localparam int LEVELS = $clog2(WIDTH);

  gp_t [WIDTH-1:0] lvl [LEVELS+1];

  assign lvl[0] = leaf_i;

  genvar k, i;
  generate
    for (k = 0; k < LEVELS; k++) begin : g_lvl
      localparam int DIST = 1 << k;
      for (i = 0; i < WIDTH; i++) begin : g_node
        if (i >= DIST) begin : g_cell
          assign lvl[k+1][i] = gp_merge(lvl[k][i], lvl[k][i-DIST]);
        end else begin : g_pass
          assign lvl[k+1][i] = lvl[k][i];
        end
      end
    end
  endgenerate

  assign pref_o = lvl[LEVELS];
endmodule

// File: rtl/ppa_tree_bk.sv
`timescale 1ns/1ps
module ppa_tree_bk #(
  parameter int WIDTH = 16
) (
  input  ppa_pkg::gp_t [WIDTH-1:0] leaf_i,
  output ppa_pkg::gp_t [WIDTH-1:0] pref_o
);
  import ppa_pkg::*;

  localparam int LEVELS = $clog2(WIDTH);
  localparam int STAGES = 2 * LEVELS - 1;

  gp_t [WIDTH-1:0] stg [STAGES+1];

  assign stg[0] = leaf_i;

  genvar t, i;
  generate
    for (t = 0; t < STAGES; t++) begin : g_stage
      // stages below LEVELS sweep up; the rest sweep back down
      localparam bit UP   = (t < LEVELS);
      localparam int SPAN = UP ? (1 << t) : (1 << (STAGES - 1 - t));
      for (i = 0; i < WIDTH; i++) begin : g_node
        localparam bit SEL = UP ? (((i + 1) % (2 * SPAN)) == 0)
                                : ((((i + 1) % (2 * SPAN)) == SPAN) && (i + 1 > SPAN));
        if (SEL) begin : g_cell
          assign stg[t+1][i] = gp_merge(stg[t][i], stg[t][i-SPAN]);
        end else begin : g_pass
          assign stg[t+1][i] = stg[t][i];
        end
      end
    end
  endgenerate

  assign pref_o = stg[STAGES];
endmodule

// File: rtl/ppa_sum.sv
`timescale 1ns/1ps
module ppa_sum #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] prop_i,
  input  logic [WIDTH-1:0] carry_pref_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  logic [WIDTH-1:0] c_in_bit;

  assign c_in_bit = {carry_pref_i[WIDTH-2:0], cin_i};
  assign sum_o    = prop_i ^ c_in_bit;
  assign cout_o   = carry_pref_i[WIDTH-1];
endmodule

// File: rtl/ppa_adder.sv
`timescale 1ns/1ps
module ppa_adder #(
  parameter int             WIDTH = 16,
  parameter ppa_pkg::tree_e TREE  = ppa_pkg::TREE_KS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  import ppa_pkg::*;

  gp_t [WIDTH-1:0] leaf;
  gp_t [WIDTH-1:0] pref;
  logic [WIDTH-1:0] prop;
  logic [WIDTH-1:0] pref_g;
  logic [WIDTH-1:0] pref_p;
  logic [WIDTH-1:0] sum_c;
  logic             cout_c;

  ppa_gp_gen #(.WIDTH(WIDTH)) u_gp (
    .a_i(a_i), .b_i(b_i), .cin_i(cin_i), .leaf_o(leaf), .prop_o(prop)
  );

  generate
    if (TREE == TREE_BK) begin : g_bk
      ppa_tree_bk #(.WIDTH(WIDTH)) u_tree (.leaf_i(leaf), .pref_o(pref));
    end else begin : g_ks
      ppa_tree_ks #(.WIDTH(WIDTH)) u_tree (.leaf_i(leaf), .pref_o(pref));
    end
  endgenerate

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_split
      assign pref_g[i] = pref[i].g;
      assign pref_p[i] = pref[i].p;
    end
  endgenerate

  ppa_sum #(.WIDTH(WIDTH)) u_sum (
    .prop_i(prop), .carry_pref_i(pref_g), .cin_i(cin_i),
    .sum_o(sum_c), .cout_o(cout_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_o  <= '0;
      cout_o <= 1'b0;
    end else begin
      sum_o  <= sum_c;
      cout_o <= cout_c;
    end
  end

  // R1 and R2: registered result matches the arithmetic sum of the previous inputs
  a_r1_sum_matches: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ({cout_o, sum_o} ==
      $past({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i})));

  // R7: reset clears both outputs
  a_r7_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (sum_o == '0 && !cout_o));

  // R5: top-bit generate forces a carry out
  a_r5_top_generate: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(a_i[WIDTH-1] & b_i[WIDTH-1])) |-> cout_o);

  // R5: top-bit kill blocks any carry out
  a_r5_top_kill: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(~a_i[WIDTH-1] & ~b_i[WIDTH-1])) |-> !cout_o);

  // R4: a full propagate chain passes the carry-in straight through
  a_r4_full_propagate: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(&(a_i ^ b_i))) |-> (cout_o == $past(cin_i)));

  // R3: every group that propagates from bit 0 upward carries exactly cin
  generate
    for (i = 0; i < WIDTH; i++) begin : g_chk
      a_r3_prefix_cin: assert property (@(posedge clk) disable iff (rst)
        pref_p[i] |-> (pref_g[i] == cin_i));
    end
  endgenerate
endmodule

// File: tb/ppa_adder_test.sv
`timescale 1ns/1ps
module ppa_adder_test;
  import ppa_pkg::*;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a = '0;
  logic [W-1:0] b = '0;
  logic         cin = 1'b0;
  logic [W-1:0] sum_ks, sum_bk;
  logic         cout_ks, cout_bk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [W:0] exp_q = '0;
  string      tag_q = "R7";

  always #2 clk = ~clk;

  ppa_adder #(.WIDTH(W), .TREE(TREE_KS)) uut (
    .clk(clk), .rst(rst), .a_i(a), .b_i(b), .cin_i(cin),
    .sum_o(sum_ks), .cout_o(cout_ks)
  );

  ppa_adder #(.WIDTH(W), .TREE(TREE_BK)) uut_bk (
    .clk(clk), .rst(rst), .a_i(a), .b_i(b), .cin_i(cin),
    .sum_o(sum_bk), .cout_o(cout_bk)
  );

  task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Compare last cycle's expectation, then apply new stimulus.
  task automatic step(input logic [W-1:0] na, input logic [W-1:0] nb,
                      input logic nc, input logic nr, input string tag);
    @(negedge clk);
    check({tag_q, " ks"}, {cout_ks, sum_ks}, exp_q);
    check({tag_q, " bk"}, {cout_bk, sum_bk}, exp_q);
    check("R8 ks vs bk", {cout_bk, sum_bk}, {cout_ks, sum_ks});
    a = na; b = nb; cin = nc; rst = nr;
    exp_q = nr ? '0 : ({1'b0, na} + {1'b0, nb} + {{W{1'b0}}, nc});
    tag_q = tag;
  endtask

  initial begin
    repeat (3) step('0, '0, 1'b0, 1'b1, "R7");
    step('0, '0, 1'b1, 1'b0, "R3");
    step('0, '0, 1'b0, 1'b0, "R3");
    step(16'hFFFF, 16'h0000, 1'b1, 1'b0, "R4");
    step(16'hFFFF, 16'h0000, 1'b0, 1'b0, "R4");
    step(16'hAAAA, 16'h5555, 1'b1, 1'b0, "R4");
    step(16'h5555, 16'hAAAA, 1'b0, 1'b0, "R4");
    step(16'h8000, 16'h8000, 1'b0, 1'b0, "R5");
    step(16'h7FFF, 16'h7FFF, 1'b1, 1'b0, "R5");
    step(16'h1234, 16'h4321, 1'b0, 1'b0, "R1");
    step(16'hFFFF, 16'hFFFF, 1'b1, 1'b1, "R7");
    step(16'h0F0F, 16'h00F1, 1'b0, 1'b0, "R6");
    step(16'h0001, 16'h0002, 1'b1, 1'b0, "R6");
    step(16'h0001, 16'h0002, 1'b1, 1'b0, "R6");
    for (int i = 0; i < W; i++)
      step({W{1'b1}}, W'(1) << i, 1'b0, 1'b0, "R2");
    for (int n = 0; n < 300; n++)
      step(W'($urandom), W'($urandom), 1'($urandom), 1'b0, "R1");
    step('0, '0, 1'b0, 1'b0, "R1");
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule